// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control unit of a small single-accumulator processor. It carries every instruction through a fixed chain of register transfers, one transfer per clock. The transfers run between a program counter, an instruction register, a memory address register, a memory data register, the accumulator and an I/O register. A state machine with one state per transfer picks the chain for each opcode. Memory is an external synchronous word array of 100 words, with read data one cycle after the address.

Two handshaked ports carry values in and out of the accumulator. Arithmetic leaves a carry flag and an overflow flag. The accumulator drives zero and non-negative indications, which the conditional branches test. The halted output goes high when a halt instruction, or any unused opcode, stops the machine.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator, the carry and overflow flags, the write strobe and the handshake outputs. The first instruction after reset is fetched from address 0.
- R2: An instruction word holds the opcode in bits 10:7 and the operand address in bits 6:0. The opcodes are 0 halt, 1 add, 2 subtract, 3 store, 4 load, 5 branch, 6 branch-if-zero, 7 branch-if-non-negative, 8 input and 9 output. Each instruction starts with a cycle that copies the program counter to the address register, so `mem_addr` equals the program counter in the second cycle. Two more cycles bring the word into the data register and then into the instruction register, and the fifth cycle decodes it.
- R3: Load, add and subtract read the word at the operand address and take 9 cycles in all. Load replaces the accumulator with the word. Add and subtract replace the accumulator with the sum or the difference, modulo 2^DATA_W.
- R4: Store takes 8 cycles. `mem_we` is high for exactly one cycle, the seventh, with `mem_addr` set to the operand address and `mem_wdata` set to the accumulator.
- R5: Input makes no memory access. It holds `in_ready` high from its sixth cycle until `in_valid` is seen, takes `in_data` into the accumulator through the I/O register, and then moves on to the next address.
- R6: Output copies the accumulator through the I/O register. From its seventh cycle it holds `out_valid` high and `out_data` steady until `out_ready` is seen, and then moves on to the next address.
- R7: Opcode 0 and the unused opcodes 10 to 15 raise `halted` after the fetch and decode. It stays high until reset, with no further fetch, no write and no handshake.
- R8: An unconditional branch loads the operand address into the program counter, so the next fetch starts five cycles after the branch began.
- R9: Branch-if-zero is taken when the accumulator is 0. Branch-if-non-negative is taken when the accumulator's top bit is 0. A taken branch loads the operand address; a branch not taken moves on to the next address. Both take five cycles.
- R10: Moving on from the last address (MEM_WORDS-1) wraps the program counter to 0.
- R11: Only add and subtract change `flag_carry` and `flag_ovf`. For add, carry is the carry out of the top bit. For subtract, carry is the borrow (subtrahend greater than minuend, unsigned). Overflow is the two's-complement overflow of the operation. `acc_zero` and `acc_pos` follow the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data (data register) |
| mem_rdata | input | DATA_W | Memory read data, one cycle after address |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Sequencer waiting for an input word |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | DATA_W | Output word (I/O register) |
| halted | output | 1 | Machine stopped |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_pos | output | 1 | Accumulator top bit clear |
| flag_carry | output | 1 | Carry/borrow of last add or subtract |
| flag_ovf | output | 1 | Signed overflow of last add or subtract |

## Verification
Each cycle is numbered from the cycle in which the program counter is copied. The fetch address appears in the second cycle, a branch target is fetched after five cycles, the store strobe appears in the seventh cycle, and the new accumulator and flags are visible when the following instruction begins. The bench's model advances one cycle per clock through the same numbering. It holds only where a wait state would stall on the handshake it drives itself. It compares the ports half a period after each edge, so every expected value is due in exactly that cycle and never one cycle early or late.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_STORE = 4'd3,
    OP_LOAD  = 4'd4,
    OP_BRA   = 4'd5,
    OP_BRZ   = 4'd6,
    OP_BRP   = 4'd7,
    OP_IN    = 4'd8,
    OP_OUT   = 4'd9
  } op_e;

  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_WAIT, ST_F_MDR, ST_F_IR, ST_DECODE,
    ST_OP_WAIT, ST_OP_MDR, ST_EXEC,
    ST_ST_MDR, ST_ST_WR,
    ST_IN_WAIT, ST_IN_ACC,
    ST_OUT_IOR, ST_OUT_WAIT,
    ST_PC_INC, ST_HALT
  } state_e;

  // one strobe per register transfer
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_from_mdr;
    logic acc_from_alu;
    logic acc_from_mdr;
    logic acc_from_ior;
    logic ior_from_in;
    logic ior_from_acc;
    logic pc_inc;
    logic pc_from_ir;
    logic we_set;
  } ctl_t;

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    res   = ext[DATA_W-1:0];
    carry = ext[DATA_W];
    if (sub) ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
    else     ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
  end
endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import acc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     opcode,
  input  logic                acc_zero,
  input  logic                acc_pos,
  input  logic                in_valid,
  input  logic                out_ready,
  output ctl_t                ctl,
  output state_e              state_q
);
  state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_F_MAR;
    else     state_q <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state_q;
    case (state_q)
      ST_F_MAR: begin
        ctl.mar_from_pc = 1'b1;
        nxt = ST_F_WAIT;
      end
      ST_F_WAIT: nxt = ST_F_MDR;
      ST_F_MDR: begin
        ctl.mdr_from_mem = 1'b1;
        nxt = ST_F_IR;
      end
      ST_F_IR: begin
        ctl.ir_from_mdr = 1'b1;
        nxt = ST_DECODE;
      end
      ST_DECODE: begin
        case (op_e'(opcode))
          OP_LOAD, OP_ADD, OP_SUB: begin
            ctl.mar_from_ir = 1'b1;
            nxt = ST_OP_WAIT;
          end
          OP_STORE: begin
            ctl.mar_from_ir = 1'b1;
            nxt = ST_ST_MDR;
          end
          OP_IN:  nxt = ST_IN_WAIT;
          OP_OUT: nxt = ST_OUT_IOR;
          OP_BRA: begin
            ctl.pc_from_ir = 1'b1;
            nxt = ST_F_MAR;
          end
          OP_BRZ: begin
            ctl.pc_from_ir = acc_zero;
            ctl.pc_inc     = !acc_zero;
            nxt = ST_F_MAR;
          end
          OP_BRP: begin
            ctl.pc_from_ir = acc_pos;
            ctl.pc_inc     = !acc_pos;
            nxt = ST_F_MAR;
          end
          default: nxt = ST_HALT;
        endcase
      end
      ST_OP_WAIT: nxt = ST_OP_MDR;
      ST_OP_MDR: begin
        ctl.mdr_from_mem = 1'b1;
        nxt = ST_EXEC;
      end
      ST_EXEC: begin
        if (op_e'(opcode) == OP_LOAD) ctl.acc_from_mdr = 1'b1;
        else                          ctl.acc_from_alu = 1'b1;
        nxt = ST_PC_INC;
      end
      ST_ST_MDR: begin
        ctl.mdr_from_acc = 1'b1;
        ctl.we_set       = 1'b1;
        nxt = ST_ST_WR;
      end
      ST_ST_WR: nxt = ST_PC_INC;
      ST_IN_WAIT: begin
        if (in_valid) begin
          ctl.ior_from_in = 1'b1;
          nxt = ST_IN_ACC;
        end
      end
      ST_IN_ACC: begin
        ctl.acc_from_ior = 1'b1;
        nxt = ST_PC_INC;
      end
      ST_OUT_IOR: begin
        ctl.ior_from_acc = 1'b1;
        nxt = ST_OUT_WAIT;
      end
      ST_OUT_WAIT: if (out_ready) nxt = ST_PC_INC;
      ST_PC_INC: begin
        ctl.pc_inc = 1'b1;
        nxt = ST_F_MAR;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_HALT;
    endcase
  end
endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 7,
  parameter int MEM_WORDS = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  ctl_t                ctl,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [DATA_W-1:0]   alu_res,
  input  logic                alu_carry,
  input  logic                alu_ovf,
  output logic [ADDR_W-1:0]   mar_q,
  output logic [DATA_W-1:0]   mdr_q,
  output logic [OP_W-1:0]     opcode,
  output logic [DATA_W-1:0]   acc_q,
  output logic [DATA_W-1:0]   ior_q,
  output logic                carry_q,
  output logic                ovf_q,
  output logic                we_q
);
  localparam int INSTR_W = OP_W + ADDR_W;
  localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(MEM_WORDS - 1);

  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic [ADDR_W-1:0]  ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];
  assign opcode  = ir_q[INSTR_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      ior_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= ctl.we_set;
      if (ctl.mar_from_pc)      mar_q <= pc_q;
      else if (ctl.mar_from_ir) mar_q <= ir_addr;
      if (ctl.mdr_from_mem)      mdr_q <= mem_rdata;
      else if (ctl.mdr_from_acc) mdr_q <= acc_q;
      if (ctl.ir_from_mdr) ir_q <= mdr_q[INSTR_W-1:0];
      if (ctl.acc_from_alu) begin
        acc_q   <= alu_res;
        carry_q <= alu_carry;
        ovf_q   <= alu_ovf;
      end else if (ctl.acc_from_mdr) begin
        acc_q <= mdr_q;
      end else if (ctl.acc_from_ior) begin
        acc_q <= ior_q;
      end
      if (ctl.ior_from_in)       ior_q <= in_data;
      else if (ctl.ior_from_acc) ior_q <= acc_q;
      if (ctl.pc_from_ir)  pc_q <= ir_addr;
      else if (ctl.pc_inc) pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 7,
  parameter int MEM_WORDS = 100
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              halted,
  output logic              acc_zero,
  output logic              acc_pos,
  output logic              flag_carry,
  output logic              flag_ovf
);
  ctl_t              ctl;
  state_e            state_q;
  logic [OP_W-1:0]   opcode;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] ior_q;
  logic [DATA_W-1:0] alu_res;
  logic              alu_carry;
  logic              alu_ovf;

  acc_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .acc_zero  (acc_zero),
    .acc_pos   (acc_pos),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .ctl       (ctl),
    .state_q   (state_q)
  );

  acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .a     (acc_q),
    .b     (mdr_q),
    .sub   (op_e'(opcode) == OP_SUB),
    .res   (alu_res),
    .carry (alu_carry),
    .ovf   (alu_ovf)
  );

  acc_seq_dp #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MEM_WORDS (MEM_WORDS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .in_data   (in_data),
    .alu_res   (alu_res),
    .alu_carry (alu_carry),
    .alu_ovf   (alu_ovf),
    .mar_q     (mem_addr),
    .mdr_q     (mdr_q),
    .opcode    (opcode),
    .acc_q     (acc_q),
    .ior_q     (ior_q),
    .carry_q   (flag_carry),
    .ovf_q     (flag_ovf),
    .we_q      (mem_we)
  );

  assign mem_wdata = mdr_q;
  assign out_data  = ior_q;
  assign in_ready  = (state_q == ST_IN_WAIT);
  assign out_valid = (state_q == ST_OUT_WAIT);
  assign halted    = (state_q == ST_HALT);
  assign acc_zero  = (acc_q == '0);
  assign acc_pos   = !acc_q[DATA_W-1];
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              halted
);
  p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_we_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(mem_addr));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !in_ready && !out_valid));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_in_alone_r5: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!out_valid && !mem_we));
endmodule

bind acc_seq_core acc_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .halted    (halted)
);

// File: tb/acc_seq_core_bench.sv
module acc_seq_core_bench;
  localparam int DW    = 12;
  localparam int AW    = 7;
  localparam int WORDS = 100;
  localparam int LIMIT = 4000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          halted;
  logic          acc_zero;
  logic          acc_pos;
  logic          flag_carry;
  logic          flag_ovf;

  always #5 clk = ~clk;

  acc_seq_core #(.DATA_W(DW), .ADDR_W(AW), .MEM_WORDS(WORDS)) u_acc_seq_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .halted(halted),
    .acc_zero(acc_zero), .acc_pos(acc_pos), .flag_carry(flag_carry),
    .flag_ovf(flag_ovf)
  );

  // environment memory, loaded through its own port while reset is held
  logic [DW-1:0] env_mem [128];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  int            cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ld_en)       env_mem[ld_addr] <= ld_data;
    else if (mem_we) env_mem[mem_addr] <= mem_wdata;
    mem_rdata <= env_mem[mem_addr];
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model state
  logic [DW-1:0] ref_mem [128];
  int            m_pc, m_k, m_op, m_addr;
  logic [DW-1:0] m_acc, m_io;
  bit            m_c, m_v;
  string         pc_tag, acc_tag;
  int            in_q[$];
  int            got_q[$];
  int            in_gate;

  function automatic int w(input int op, input int a);
    return op * 128 + a;
  endfunction

  function automatic int nxt_pc(input int pc);
    return (pc == WORDS - 1) ? 0 : pc + 1;
  endfunction

  function automatic bit is_halt(input int op);
    return (op == 0) || (op > 9);
  endfunction

  task automatic model_reset();
    m_pc = 0; m_k = 0; m_op = 0; m_addr = 0;
    m_acc = '0; m_io = '0; m_c = 0; m_v = 0;
    pc_tag = "R1"; acc_tag = "R1";
  endtask

  task automatic advance_pc();
    if (m_pc == WORDS - 1) pc_tag = "R10";
    else                   pc_tag = "R2";
    m_pc = nxt_pc(m_pc);
    m_k  = 0;
  endtask

  task automatic step();
    logic [DW:0] e;
    if (m_k < 4) begin
      if (m_k == 0) begin
        m_op   = int'(ref_mem[m_pc][10:7]);
        m_addr = int'(ref_mem[m_pc][6:0]);
      end
      m_k++;
    end else if (m_k == 4) begin
      if (is_halt(m_op)) m_k = 5;
      else if (m_op == 5) begin m_pc = m_addr; pc_tag = "R8"; m_k = 0; end
      else if (m_op == 6) begin
        if (m_acc == 0) m_pc = m_addr; else m_pc = nxt_pc(m_pc);
        pc_tag = "R9"; m_k = 0;
      end else if (m_op == 7) begin
        if (!m_acc[DW-1]) m_pc = m_addr; else m_pc = nxt_pc(m_pc);
        pc_tag = "R9"; m_k = 0;
      end else m_k = 5;
    end else if (is_halt(m_op)) begin
      m_k = 5;
    end else if (m_op == 4 || m_op == 1 || m_op == 2) begin
      if (m_k == 7) begin
        if (m_op == 4) m_acc = ref_mem[m_addr];
        else begin
          if (m_op == 1) e = {1'b0, m_acc} + {1'b0, ref_mem[m_addr]};
          else           e = {1'b0, m_acc} - {1'b0, ref_mem[m_addr]};
          m_c = e[DW];
          if (m_op == 1) m_v = (m_acc[DW-1] == ref_mem[m_addr][DW-1]) && (e[DW-1] != m_acc[DW-1]);
          else           m_v = (m_acc[DW-1] != ref_mem[m_addr][DW-1]) && (e[DW-1] != m_acc[DW-1]);
          m_acc = e[DW-1:0];
        end
        acc_tag = "R3";
      end
      if (m_k == 8) advance_pc(); else m_k++;
    end else if (m_op == 3) begin
      if (m_k == 6) ref_mem[m_addr] = m_acc;
      if (m_k == 7) advance_pc(); else m_k++;
    end else if (m_op == 8) begin
      if (m_k == 5) begin
        if (in_valid) begin
          m_io = in_data;
          void'(in_q.pop_front());
          in_gate = cyc + 3;
          m_k = 6;
        end
      end else if (m_k == 6) begin
        m_acc = m_io; acc_tag = "R5"; m_k = 7;
      end else advance_pc();
    end else begin
      if (m_k == 5) m_k = 6;
      else if (m_k == 6) begin if (out_ready) m_k = 7; end
      else advance_pc();
    end
  endtask

  task automatic compare();
    bit e_halt, e_in, e_out, e_we;
    e_halt = is_halt(m_op) && (m_k >= 5);
    e_in   = (m_op == 8) && (m_k == 5);
    e_out  = (m_op == 9) && (m_k == 6);
    e_we   = (m_op == 3) && (m_k == 6);
    chk(halted == e_halt, "R7", "halted", halted, e_halt);
    chk(in_ready == e_in, "R5", "in_ready", in_ready, e_in);
    chk(out_valid == e_out, "R6", "out_valid", out_valid, e_out);
    if (e_out) chk(out_data == m_acc, "R6", "out_data", out_data, m_acc);
    chk(mem_we == e_we, "R4", "mem_we", mem_we, e_we);
    if (e_we) begin
      chk(mem_addr == AW'(m_addr), "R4", "store address", mem_addr, m_addr);
      chk(mem_wdata == m_acc, "R4", "store data", mem_wdata, m_acc);
    end
    if (m_k == 1) chk(mem_addr == AW'(m_pc), pc_tag, "fetch address", mem_addr, m_pc);
    if (m_k == 0) begin
      chk(acc_zero == (m_acc == 0), acc_tag, "acc_zero", acc_zero, m_acc == 0);
      chk(acc_pos == !m_acc[DW-1], acc_tag, "acc_pos", acc_pos, !m_acc[DW-1]);
      chk(flag_carry == m_c, "R11", "carry", flag_carry, m_c);
      chk(flag_ovf == m_v, "R11", "overflow", flag_ovf, m_v);
    end
  endtask

  // one clock: drive at the falling edge, check just after, then advance the model
  task automatic one_cycle();
    in_valid  = (in_q.size() > 0) && (cyc >= in_gate);
    in_data   = (in_q.size() > 0) ? DW'(in_q[0]) : '0;
    out_ready = ((cyc % 4) == 3);
    #1;
    if (out_valid && out_ready) got_q.push_back(int'(out_data));
    compare();
    step();
    @(negedge clk);
  endtask

  task automatic load_env();
    for (int i = 0; i < 128; i++) begin
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = ref_mem[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic reset_check();
    #1;
    chk(halted == 0, "R1", "halted in reset", halted, 0);
    chk(mem_we == 0, "R1", "mem_we in reset", mem_we, 0);
    chk(in_ready == 0 && out_valid == 0, "R1", "handshakes in reset", {in_ready, out_valid}, 0);
    chk(acc_zero == 1 && acc_pos == 1, "R1", "accumulator cleared", {acc_zero, acc_pos}, 3);
    chk(flag_carry == 0 && flag_ovf == 0, "R1", "flags cleared", {flag_carry, flag_ovf}, 0);
  endtask

  task automatic run(output bit timed_out);
    int idle;
    idle = 0;
    timed_out = 0;
    for (int n = 0; n < LIMIT && idle < 12; n++) begin
      one_cycle();
      if (is_halt(m_op) && m_k >= 5) idle++;
    end
    if (idle < 12) timed_out = 1;
  endtask

  initial begin
    bit to;
    @(negedge clk);
    // program A: I/O, store, arithmetic with flags, all branch kinds, wrap, unused opcode
    for (int i = 0; i < 128; i++) ref_mem[i] = '0;
    ref_mem[0]  = DW'(w(8, 0));   ref_mem[1]  = DW'(w(3, 90));
    ref_mem[2]  = DW'(w(8, 0));   ref_mem[3]  = DW'(w(1, 90));
    ref_mem[4]  = DW'(w(9, 0));   ref_mem[5]  = DW'(w(2, 91));
    ref_mem[6]  = DW'(w(6, 9));   ref_mem[7]  = DW'(w(0, 0));
    ref_mem[8]  = DW'(w(0, 0));   ref_mem[9]  = DW'(w(4, 92));
    ref_mem[10] = DW'(w(1, 93));  ref_mem[11] = DW'(w(7, 7));
    ref_mem[12] = DW'(w(9, 0));   ref_mem[13] = DW'(w(6, 7));
    ref_mem[14] = DW'(w(4, 94));  ref_mem[15] = DW'(w(1, 93));
    ref_mem[16] = DW'(w(7, 18));  ref_mem[17] = DW'(w(0, 0));
    ref_mem[18] = DW'(w(2, 93));  ref_mem[19] = DW'(w(5, 97));
    ref_mem[40] = DW'(w(12, 0));
    ref_mem[91] = 12'd12;  ref_mem[92] = 12'd2047; ref_mem[93] = 12'd1;
    ref_mem[94] = 12'd4095; ref_mem[96] = DW'(w(5, 40));
    ref_mem[97] = DW'(w(9, 0));  ref_mem[98] = DW'(w(4, 96));
    ref_mem[99] = DW'(w(3, 0));
    load_env();
    reset_check();
    model_reset();
    in_q = '{5, 7};
    got_q = {};
    in_gate = 0;
    rst = 1'b0;
    run(to);
    chk(!to, "R7", "program A reached halt before watchdog", to, 0);
    chk(got_q.size() == 3, "R6", "program A output count", got_q.size(), 3);
    if (got_q.size() == 3) begin
      chk(got_q[0] == 12, "R3", "sum of two inputs", got_q[0], 12);
      chk(got_q[1] == 2048, "R11", "wrapped signed sum", got_q[1], 2048);
      chk(got_q[2] == 4095, "R9", "value after taken non-negative branch", got_q[2], 4095);
    end
    chk(in_q.size() == 0, "R5", "all input words taken", in_q.size(), 0);
    chk(env_mem[0] == DW'(w(5, 40)), "R4", "word stored over address 0", env_mem[0], w(5, 40));

    // program B: reset mid-halt, accumulator output, opcode 0 halt
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 128; i++) ref_mem[i] = '0;
    ref_mem[0] = DW'(w(9, 0));
    ref_mem[1] = DW'(w(0, 0));
    load_env();
    reset_check();
    model_reset();
    got_q = {};
    rst = 1'b0;
    run(to);
    chk(!to, "R7", "program B reached halt before watchdog", to, 0);
    chk(got_q.size() == 1 && got_q[0] == 0, "R1", "accumulator zero after reset",
        (got_q.size() > 0) ? got_q[0] : -1, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10 - 100);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule